// File: doc/BRIEF.md
# UDP Header Template Inserter

This block builds the header of an Ethernet/IPv4/UDP frame from a header template that software programs. It then streams the frame's payload behind that header. Software fills the template over a write-only settings port. Each slot holds one 16-bit header word together with six control flags. The same port also loads a small table of UDP port numbers. The table holds a pair of ports for each of two streams.

A packet begins when the start handshake is accepted. The start request carries the payload length in bytes and a stream select. The block then walks the template from slot 2 upward and sends one 16-bit word per accepted output beat. Where a slot's flags ask for it, the block replaces the written data with a computed value: the UDP length, the IP total length, the finished IP header checksum, or a port from the table. The walk stops after the slot marked as the last one. The payload stream then passes straight through to the output until its final beat has been accepted. The UDP checksum is sent exactly as software wrote it.

Top module: `udp_hdr_inserter`

## Requirements
- R1: While reset is held and right after it, out_valid is 0, pl_ready is 0 and start_ready is 1.
- R2: Accepting a start request makes the first header word valid on the next cycle, with out_sop set. That word is taken from template slot 2, and later words come from consecutive higher slots. Slots 0 and 1 can be written but are never sent, and out_sop is 1 only on the first header word.
- R3: A slot whose flag bit 19 is set is the last header word. If no slot carries that flag, slot 22 ends the header.
- R4: Flag bit 16 sends payload length + 8, the UDP length. Flag bit 17 sends payload length + 28, the IP total length. In both cases the slot's data bits are ignored.
- R5: Flag bit 18 sends the finished IP checksum. The block adds the IP total length to the slot's 16-bit preload, adds back the carry out of bit 15 (end-around carry), and sends the ones' complement of the result.
- R6: Flag bit 21 sends the source port and flag bit 20 sends the destination port. For stream select s, the source port is table entry 2*s and the destination port is entry 2*s+1. Table entries 0 to 3 are written at settings addresses 24 to 27.
- R7: While out_valid is high and out_ready is low, out_data does not change and the header does not advance.
- R8: Once the last header word has been accepted, payload beats pass through unchanged. out_data follows pl_data, out_valid follows pl_valid, out_eop follows pl_last and pl_ready follows out_ready. pl_ready stays 0 during the header. start_ready returns to 1 after the beat with pl_last has been accepted.
- R9: Settings writes to address 23 and to addresses 28 to 31 change nothing. Bits 31:22 of any write are ignored. A template slot write stores data from bits 15:0 and flags from bits 21:16.
- R10: A start request made while a packet is in progress is not accepted and does not change the lengths or ports of that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 5 | Settings address: slots 0-22, port table 24-27 |
| cfg_data | input | 32 | Settings write data |
| start_valid | input | 1 | Packet start request |
| start_ready | output | 1 | Block is idle and will accept a start request |
| start_len | input | 16 | Payload length in bytes |
| start_sel | input | 1 | Stream select for the port table |
| pl_valid | input | 1 | Payload beat valid |
| pl_ready | output | 1 | Payload beat accepted |
| pl_data | input | 16 | Payload word |
| pl_last | input | 1 | Final payload beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 16 | Output word |
| out_sop | output | 1 | First header word |
| out_eop | output | 1 | Final beat of the packet |

## Verification
The bench targets the checksum case where the preload plus the length overflows 16 bits. A design that dropped the end-around carry would send a checksum that is off by one. It also runs templates with the last-word flag on an early slot and with no last-word flag at all. A wrong stop condition would then cut the header short or walk past slot 22 into the port table. Other tests stall the output in the middle of the header, select the second stream, write to the unused and out-of-range addresses, and raise a start request while a packet is running. These catch, in turn, a word pointer that advances without a handshake, swapped or misindexed port entries, writes that alias onto real slots, and a busy block that re-latches its lengths.

// File: rtl/udp_hdr_pkg.sv
package udp_hdr_pkg;

    localparam int WORD_W     = 16;
    localparam int FLAG_W     = 6;
    localparam int ENTRY_W    = WORD_W + FLAG_W;
    localparam int CFG_AW     = 5;
    localparam int CFG_DW     = 32;
    localparam int SLOT_N     = 23;
    localparam int FIRST_SLOT = 2;
    localparam int PORT_BASE  = 24;
    localparam int PORT_N     = 4;
    localparam int SEL_W      = $clog2(PORT_N / 2);
    localparam int IP_EXTRA   = 28;
    localparam int UDP_EXTRA  = 8;

    // Flag field occupies entry bits 21:16, listed from bit 21 down to bit 16.
    typedef struct packed {
        logic src_port;
        logic dst_port;
        logic last;
        logic ip_csum;
        logic ip_len;
        logic udp_len;
    } tmpl_flags_t;

    typedef struct packed {
        tmpl_flags_t       flags;
        logic [WORD_W-1:0] data;
    } tmpl_entry_t;

    typedef struct packed {
        logic [WORD_W-1:0] ip_len;
        logic [WORD_W-1:0] udp_len;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
    } pkt_ctx_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_BODY = 2'd2
    } ins_state_t;

    // Ones' complement add with end-around carry, then invert.
    function automatic logic [WORD_W-1:0] csum_finish(
        input logic [WORD_W-1:0] pre,
        input logic [WORD_W-1:0] add
    );
        logic [WORD_W:0] s;
        s = {1'b0, pre} + {1'b0, add};
        return ~(s[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, s[WORD_W]});
    endfunction

endpackage

// File: rtl/udp_hdr_tmpl_regs.sv
module udp_hdr_tmpl_regs
    import udp_hdr_pkg::*;
#(
    parameter int SLOTS = SLOT_N,
    parameter int PORTS = PORT_N,
    parameter int PBASE = PORT_BASE,
    parameter int AW    = CFG_AW,
    parameter int DW    = CFG_DW
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [DW-1:0]                wr_data,
    input  logic [AW-1:0]                rd_slot,
    output tmpl_entry_t                  rd_entry,
    output logic [PORTS-1:0][WORD_W-1:0] port_tbl
);

    tmpl_entry_t slots [SLOTS];
    logic [PORTS-1:0][WORD_W-1:0] ports_q;

    logic slot_hit;
    logic port_hit;
    logic [AW-1:0] port_idx;

    always_comb begin
        slot_hit = wr_en && (int'(wr_addr) < SLOTS);
        port_hit = wr_en && (int'(wr_addr) >= PBASE) && (int'(wr_addr) < PBASE + PORTS);
        port_idx = wr_addr - AW'(PBASE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
        end else if (slot_hit) begin
            slots[wr_addr] <= tmpl_entry_t'(wr_data[ENTRY_W-1:0]);
        end
    end

    generate
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            always_ff @(posedge clk) begin
                if (rst) begin
                    ports_q[p] <= '0;
                end else if (port_hit && (int'(port_idx) == p)) begin
                    ports_q[p] <= wr_data[WORD_W-1:0];
                end
            end
        end
    endgenerate

    always_comb begin
        rd_entry = '0;
        if (int'(rd_slot) < SLOTS) rd_entry = slots[rd_slot];
        port_tbl = ports_q;
    end

endmodule

// File: rtl/udp_hdr_field_sub.sv
module udp_hdr_field_sub
    import udp_hdr_pkg::*;
(
    input  tmpl_entry_t       ent,
    input  pkt_ctx_t          ctx,
    output logic [WORD_W-1:0] word,
    output logic              word_last
);

    // Flags other than "last" are exclusive by contract; a fixed order
    // resolves any overlap deterministically.
    always_comb begin
        if (ent.flags.udp_len) begin
            word = ctx.udp_len;
        end else if (ent.flags.ip_len) begin
            word = ctx.ip_len;
        end else if (ent.flags.ip_csum) begin
            word = csum_finish(ent.data, ctx.ip_len);
        end else if (ent.flags.dst_port) begin
            word = ctx.dst;
        end else if (ent.flags.src_port) begin
            word = ctx.src;
        end else begin
            word = ent.data;
        end
        word_last = ent.flags.last;
    end

endmodule

// File: rtl/udp_hdr_seq.sv
module udp_hdr_seq
    import udp_hdr_pkg::*;
#(
    parameter int AW    = CFG_AW,
    parameter int FIRST = FIRST_SLOT,
    parameter int LAST  = SLOT_N - 1,
    parameter int PORTS = PORT_N,
    parameter int SW    = SEL_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_valid,
    output logic                         start_ready,
    input  logic [WORD_W-1:0]            start_len,
    input  logic [SW-1:0]                start_sel,
    input  logic [PORTS-1:0][WORD_W-1:0] port_tbl,
    input  logic [WORD_W-1:0]            hdr_word,
    input  logic                         hdr_word_last,
    output logic [AW-1:0]                slot_ptr,
    output pkt_ctx_t                     ctx,
    output logic                         hdr_active,
    input  logic                         pl_valid,
    output logic                         pl_ready,
    input  logic [WORD_W-1:0]            pl_data,
    input  logic                         pl_last,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [WORD_W-1:0]            out_data,
    output logic                         out_sop,
    output logic                         out_eop
);

    ins_state_t state;
    logic [AW-1:0] ptr;
    pkt_ctx_t ctx_q;
    logic hdr_end;
    int src_idx;

    always_comb begin
        hdr_end = hdr_word_last || (int'(ptr) == LAST);
        src_idx = 2 * int'(start_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ptr   <= AW'(FIRST);
            ctx_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_valid) begin
                        state <= ST_HDR;
                        ptr   <= AW'(FIRST);
                        ctx_q <= '{ip_len:  start_len + WORD_W'(IP_EXTRA),
                                   udp_len: start_len + WORD_W'(UDP_EXTRA),
                                   src:     port_tbl[src_idx],
                                   dst:     port_tbl[src_idx + 1]};
                    end
                end
                ST_HDR: begin
                    if (out_ready) begin
                        if (hdr_end) state <= ST_BODY;
                        else         ptr   <= ptr + AW'(1);
                    end
                end
                ST_BODY: begin
                    if (out_ready && pl_valid && pl_last) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        start_ready = (state == ST_IDLE);
        hdr_active  = (state == ST_HDR);
        slot_ptr    = ptr;
        ctx         = ctx_q;
        out_valid   = 1'b0;
        out_data    = '0;
        out_sop     = 1'b0;
        out_eop     = 1'b0;
        pl_ready    = 1'b0;
        case (state)
            ST_HDR: begin
                out_valid = 1'b1;
                out_data  = hdr_word;
                out_sop   = (int'(ptr) == FIRST);
            end
            ST_BODY: begin
                out_valid = pl_valid;
                out_data  = pl_data;
                out_eop   = pl_last;
                pl_ready  = out_ready;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/udp_hdr_inserter.sv
module udp_hdr_inserter
    import udp_hdr_pkg::*;
#(
    parameter int SLOTS = SLOT_N,
    parameter int PORTS = PORT_N
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [CFG_DW-1:0]    cfg_data,
    input  logic                 start_valid,
    output logic                 start_ready,
    input  logic [WORD_W-1:0]    start_len,
    input  logic [SEL_W-1:0]     start_sel,
    input  logic                 pl_valid,
    output logic                 pl_ready,
    input  logic [WORD_W-1:0]    pl_data,
    input  logic                 pl_last,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [WORD_W-1:0]    out_data,
    output logic                 out_sop,
    output logic                 out_eop
);

    tmpl_entry_t                  cur_entry;
    logic [PORTS-1:0][WORD_W-1:0] port_tbl;
    logic [CFG_AW-1:0]            slot_ptr;
    pkt_ctx_t                     ctx;
    logic [WORD_W-1:0]            hdr_word;
    logic                         hdr_word_last;
    logic                         hdr_active;

    udp_hdr_tmpl_regs #(
        .SLOTS (SLOTS),
        .PORTS (PORTS),
        .PBASE (PORT_BASE),
        .AW    (CFG_AW),
        .DW    (CFG_DW)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_data),
        .rd_slot  (slot_ptr),
        .rd_entry (cur_entry),
        .port_tbl (port_tbl)
    );

    udp_hdr_field_sub u_field (
        .ent       (cur_entry),
        .ctx       (ctx),
        .word      (hdr_word),
        .word_last (hdr_word_last)
    );

    udp_hdr_seq #(
        .AW    (CFG_AW),
        .FIRST (FIRST_SLOT),
        .LAST  (SLOTS - 1),
        .PORTS (PORTS),
        .SW    (SEL_W)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_valid   (start_valid),
        .start_ready   (start_ready),
        .start_len     (start_len),
        .start_sel     (start_sel),
        .port_tbl      (port_tbl),
        .hdr_word      (hdr_word),
        .hdr_word_last (hdr_word_last),
        .slot_ptr      (slot_ptr),
        .ctx           (ctx),
        .hdr_active    (hdr_active),
        .pl_valid      (pl_valid),
        .pl_ready      (pl_ready),
        .pl_data       (pl_data),
        .pl_last       (pl_last),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_data      (out_data),
        .out_sop       (out_sop),
        .out_eop       (out_eop)
    );

endmodule

// File: rtl/udp_hdr_inserter_chk.sv
module udp_hdr_inserter_chk
    import udp_hdr_pkg::*;
#(
    parameter int SLOTS = SLOT_N
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              start_valid,
    input logic              start_ready,
    input logic              pl_valid,
    input logic              pl_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic              out_sop,
    input logic              out_eop,
    input logic              hdr_active,
    input logic [CFG_AW-1:0] slot_ptr
);

    assert_start_opens_header_R2: assert property (@(posedge clk) disable iff (rst)
        (start_valid && start_ready) |=> (out_valid && out_sop && hdr_active));

    assert_single_sop_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sop && out_ready) |=> !out_sop);

    assert_ptr_window_R3: assert property (@(posedge clk) disable iff (rst)
        hdr_active |-> (int'(slot_ptr) >= FIRST_SLOT && int'(slot_ptr) <= SLOTS - 1));

    assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (hdr_active && out_valid && !out_ready && !cfg_we) |=>
            (out_valid && $stable(out_data) && $stable(slot_ptr)));

    assert_no_payload_in_header_R8: assert property (@(posedge clk) disable iff (rst)
        hdr_active |-> (!pl_ready && !out_eop));

    assert_body_follows_input_R8: assert property (@(posedge clk) disable iff (rst)
        (!hdr_active && !start_ready) |-> (out_valid == pl_valid && pl_ready == out_ready));

    assert_busy_refuses_start_R10: assert property (@(posedge clk) disable iff (rst)
        hdr_active |-> !start_ready);

endmodule

bind udp_hdr_inserter udp_hdr_inserter_chk #(.SLOTS(SLOTS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .pl_valid    (pl_valid),
    .pl_ready    (pl_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .hdr_active  (hdr_active),
    .slot_ptr    (slot_ptr)
);

// File: tb/tb_udp_hdr_inserter.sv
module tb_udp_hdr_inserter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_data = '0;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [15:0] start_len = '0;
    logic [0:0]  start_sel = '0;
    logic        pl_valid = 1'b0;
    logic        pl_ready;
    logic [15:0] pl_data = '0;
    logic        pl_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;
    logic        out_sop;
    logic        out_eop;

    always #2 clk = ~clk;

    udp_hdr_inserter dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .start_valid(start_valid), .start_ready(start_ready), .start_len(start_len),
        .start_sel(start_sel), .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .pl_last(pl_last), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic [21:0] tm [0:22];
    logic [15:0] pt [0:3];

    logic [15:0] cap_d [0:63];
    bit          cap_s [0:63];
    bit          cap_e [0:63];
    int          cap_n;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input int addr, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_data = val;
        @(negedge clk);
        cfg_we = 1'b0;
        // R9: model keeps only bits 21:0, only addresses 0-22 and 24-27
        if (addr < 23) tm[addr] = val[21:0];
        else if (addr >= 24 && addr <= 27) pt[addr-24] = val[15:0];
    endtask

    function automatic logic [15:0] exp_word(input int slot, input int len, input int sel);
        logic [15:0] d;
        logic [5:0] f;
        logic [16:0] s;
        d = tm[slot][15:0];
        f = tm[slot][21:16];
        if (f[0]) return 16'(len + 8);
        if (f[1]) return 16'(len + 28);
        if (f[2]) begin
            s = {1'b0, d} + {1'b0, 16'(len + 28)};
            return ~(s[15:0] + {15'd0, s[16]});
        end
        if (f[4]) return pt[2*sel+1];
        if (f[5]) return pt[2*sel];
        return d;
    endfunction

    function automatic string req_of(input int slot);
        logic [5:0] f;
        f = tm[slot][21:16];
        if (f[0] || f[1]) return "R4";
        if (f[2]) return "R5";
        if (f[4] || f[5]) return "R6";
        return "R2";
    endfunction

    function automatic int exp_hdr_count();
        for (int s = 2; s <= 22; s++) if (tm[s][19]) return s - 1;
        return 21;
    endfunction

    task automatic run_pkt(input int len, input int sel, input int npl, input bit stall, input bit poke);
        int pi;
        bit done;
        bit holding;
        logic [15:0] held;
        @(negedge clk);
        start_valid = 1'b1; start_len = 16'(len); start_sel = 1'(sel);
        #1;
        check("R8", "start_ready before start", int'(start_ready), 1);
        @(posedge clk);
        cap_n = 0; pi = 0; done = 0; holding = 0; held = '0;
        for (int c = 0; c < 400 && !done; c++) begin
            @(negedge clk);
            if (poke) begin
                start_valid = 1'b1; start_len = 16'd999; start_sel = 1'(~sel);
            end else begin
                start_valid = 1'b0;
            end
            out_ready = stall ? (c % 3 != 1) : 1'b1;
            pl_valid  = (pi < npl);
            pl_data   = 16'hB000 + 16'(pi);
            pl_last   = (pi == npl - 1);
            #1;
            if (holding) begin
                check("R7", "stalled beat still valid", int'(out_valid), 1);
                check("R7", "stalled word stable", int'(out_data), int'(held));
            end
            holding = 0;
            if (out_valid && !out_ready) begin
                holding = 1; held = out_data;
            end
            if (out_valid && out_ready && cap_n < 64) begin
                cap_d[cap_n] = out_data; cap_s[cap_n] = out_sop; cap_e[cap_n] = out_eop;
                cap_n++;
                if (out_eop) done = 1;
            end
            if (pl_valid && pl_ready) pi++;
            @(posedge clk);
        end
        #1;
        start_valid = 1'b0; pl_valid = 1'b0; pl_last = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        #1;
        check("R8", "start_ready after eop", int'(start_ready), 1);
        check("R8", "out_valid idle", int'(out_valid), 0);
    endtask

    task automatic verify(input string scen, input int len, input int sel, input int npl);
        int nh;
        nh = exp_hdr_count();
        check("R3", {scen, " beat count"}, cap_n, nh + npl);
        for (int i = 0; i < nh && i < cap_n; i++) begin
            check(req_of(i + 2), $sformatf("%s header word %0d", scen, i), int'(cap_d[i]),
                  int'(exp_word(i + 2, len, sel)));
            check("R2", $sformatf("%s sop on word %0d", scen, i), int'(cap_s[i]), (i == 0) ? 1 : 0);
            check("R8", $sformatf("%s no eop in header %0d", scen, i), int'(cap_e[i]), 0);
        end
        for (int j = 0; j < npl && nh + j < cap_n; j++) begin
            check("R8", $sformatf("%s payload %0d", scen, j), int'(cap_d[nh + j]), int'(16'hB000 + 16'(j)));
            check("R8", $sformatf("%s payload eop %0d", scen, j), int'(cap_e[nh + j]), (j == npl - 1) ? 1 : 0);
        end
    endtask

    task automatic program_template();
        write_cfg(0, 32'h0000_DEAD);
        write_cfg(1, 32'h0000_DEAD);
        for (int s = 2; s <= 22; s++) write_cfg(s, 32'h1100 + s);
        write_cfg(9,  32'h0000_4500);
        write_cfg(10, (32'd1 << 17) | 32'h7777);
        write_cfg(14, (32'd1 << 18) | 32'hFFF0);
        write_cfg(19, (32'd1 << 21) | 32'h5555);
        write_cfg(20, (32'd1 << 20) | 32'h6666);
        write_cfg(21, (32'd1 << 16) | 32'h8888);
        write_cfg(22, (32'd1 << 19) | 32'h1234);
        write_cfg(24, 32'h1000);
        write_cfg(25, 32'h1001);
        write_cfg(26, 32'h2000);
        write_cfg(27, 32'h2001);
    endtask

    task automatic test_reset();
        #1;
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "pl_ready in reset", int'(pl_ready), 0);
        @(negedge clk); rst = 1'b0; #1;
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "start_ready after reset", int'(start_ready), 1);
        check("R1", "pl_ready after reset", int'(pl_ready), 0);
    endtask

    task automatic test_basic();
        // length 100: IP length 0x80, checksum preload 0xFFF0 overflows (R5)
        run_pkt(100, 0, 4, 1'b0, 1'b0);
        verify("basic", 100, 0, 4);
        check("R5", "carry checksum", int'(cap_d[12]), int'(16'hFF8E));
    endtask

    task automatic test_stream1_stall();
        run_pkt(36, 1, 3, 1'b1, 1'b0);
        verify("stream1 stall", 36, 1, 3);
        check("R6", "src port stream1", int'(cap_d[17]), int'(16'h2000));
        check("R6", "dst port stream1", int'(cap_d[18]), int'(16'h2001));
    endtask

    task automatic test_early_last();
        write_cfg(8, (32'd1 << 19) | 32'h1108);
        run_pkt(10, 0, 2, 1'b0, 1'b0);
        verify("early last", 10, 0, 2);
        check("R3", "early end header words", cap_n - 2, 7);
        write_cfg(8, 32'h1108);
    endtask

    task automatic test_no_last();
        write_cfg(22, 32'h1234);
        run_pkt(20, 1, 2, 1'b0, 1'b0);
        verify("no last flag", 20, 1, 2);
        check("R3", "forced end header words", cap_n - 2, 21);
        write_cfg(22, (32'd1 << 19) | 32'h1234);
    endtask

    task automatic test_ignored_writes();
        write_cfg(23, 32'hFFFF_FFFF);
        for (int a = 28; a <= 31; a++) write_cfg(a, 32'h003F_ABCD);
        write_cfg(9, 32'hFFC0_4501);
        run_pkt(50, 0, 2, 1'b0, 1'b0);
        verify("R9 ignored writes", 50, 0, 2);
        check("R9", "src port untouched", int'(cap_d[17]), int'(16'h1000));
        check("R9", "slot9 upper bits dropped", int'(cap_d[7]), int'(16'h4501));
    endtask

    task automatic test_busy_start();
        run_pkt(64, 1, 3, 1'b1, 1'b1);
        verify("R10 busy start", 64, 1, 3);
        check("R10", "ip length kept", int'(cap_d[8]), 64 + 28);
    endtask

    initial begin
        #600000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 23; s++) tm[s] = '0;
        for (int p = 0; p < 4; p++) pt[p] = '0;
        repeat (3) @(posedge clk);
        test_reset();
        program_template();
        test_basic();
        test_stream1_stall();
        test_early_last();
        test_no_last();
        test_ignored_writes();
        test_busy_start();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule